// File: doc/BRIEF.md
# Excess-Three Decimal Digit Adder

This combinational block adds two decimal numbers held in excess-three code, together with a one-bit carry-in. It produces an excess-three sum and a decimal carry-out. Each decimal digit is coded as its value plus three, so the legal four-bit codes run from 0011 (zero) to 1100 (nine).

Each digit cell works in two stages. The first stage is a plain 4-bit binary addition of the two codes and the incoming carry. It gives a raw carry and a raw nibble, which together hold the decimal sum offset by six. A second 4-bit binary addition then applies a correction constant, and the carry of that second addition is thrown away. The raw carry picks the constant and also serves directly as the decimal carry-out, so no separate overflow decode is needed.

A parameter sets how many digit cells are chained. Each cell's carry feeds the cell above it. Inputs that are not legal excess-three codes give undefined results.

Top module: `xs3_digit_adder`

## Requirements
- R1: Digit i of every operand and of the sum occupies bits [4i+3:4i], least significant digit at i=0, and a decimal value d is coded as the binary value d+3.
- R2: For legal input codes, each cell's sum digit is the code of (a + b + carry-in) mod 10, where a and b are the decimal values of its two input digits.
- R3: A cell's carry-out is 1 exactly when a + b + carry-in is 10 or more.
- R4: For legal input codes, every output digit lies in 0011..1100. The correction adds 1101 modulo 16 when the raw binary carry is 0 and adds 0011 when it is 1.
- R5: When both operands are decimal zero (all digits 0011) and the carry-in is 0, the sum is all 0011 and the carry-out is 0.
- R6: When both operands are all nines (all digits 1100) and the carry-in is 1, the sum is all 1100 and the carry-out is 1.
- R7: Each digit's carry-out drives the carry-in of the next digit up, and the top digit's carry-out is carry_o. The whole output equals the decimal sum of the operands plus the carry-in.
- R8: The block has no clock. Its outputs follow an input change within the same evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aug_i | input | 4*NUM_DIGITS | Augend, excess-three digits |
| add_i | input | 4*NUM_DIGITS | Addend, excess-three digits |
| carry_i | input | 1 | Decimal carry into the lowest digit |
| sum_o | output | 4*NUM_DIGITS | Sum, excess-three digits |
| carry_o | output | 1 | Decimal carry out of the top digit |

## Verification
The lowest cell is driven through all 200 combinations of two legal digits and a carry-in. This covers the raw-carry-zero correction and the raw-carry-one correction, and the boundary between sums of 9 and 10. The upper cell is then swept in the same way while the lower digits always generate a carry. This separates a correct carry hand-off between cells from a cell that only works when fed directly from carry_i. A stride over whole two-digit operands, the all-zero and all-nine corners, and checks taken right after an input change without any clock edge complete the set.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  // correction added to the raw nibble, selected by the raw binary carry
  localparam digit_t CORR_NO_CARRY = 4'b1101;
  localparam digit_t CORR_CARRY    = 4'b0011;
endpackage

// File: rtl/xs3_nibble_add.sv
module xs3_nibble_add #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] s_o,
  output logic             co_o
);
  logic [WIDTH:0] total;

  always_comb begin
    total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ci_i};
  end

  assign s_o  = total[WIDTH-1:0];
  assign co_o = total[WIDTH];
endmodule

// File: rtl/xs3_corr_sel.sv
module xs3_corr_sel
  import xs3_pkg::*;
(
  input  logic   raw_carry_i,
  output digit_t corr_o
);
  always_comb begin
    corr_o = raw_carry_i ? CORR_CARRY : CORR_NO_CARRY;
  end
endmodule

// File: rtl/xs3_digit_cell.sv
module xs3_digit_cell
  import xs3_pkg::*;
(
  input  digit_t aug_i,
  input  digit_t add_i,
  input  logic   carry_i,
  output digit_t sum_o,
  output logic   carry_o
);
  digit_t raw_sum;
  logic   raw_carry;
  digit_t corr;
  logic   unused_fix_carry;

  // stage one: plain binary add, result is the decimal sum offset by six
  xs3_nibble_add #(.WIDTH(DIGIT_W)) u_raw_add (
    .a_i  (aug_i),
    .b_i  (add_i),
    .ci_i (carry_i),
    .s_o  (raw_sum),
    .co_o (raw_carry)
  );

  xs3_corr_sel u_corr (
    .raw_carry_i (raw_carry),
    .corr_o      (corr)
  );

  // stage two: bring the offset back to three, carry discarded
  xs3_nibble_add #(.WIDTH(DIGIT_W)) u_fix_add (
    .a_i  (raw_sum),
    .b_i  (corr),
    .ci_i (1'b0),
    .s_o  (sum_o),
    .co_o (unused_fix_carry)
  );

  assign carry_o = raw_carry;
endmodule

// File: rtl/xs3_digit_adder.sv
module xs3_digit_adder
  import xs3_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic [DIGIT_W*NUM_DIGITS-1:0] aug_i,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] add_i,
  input  logic                          carry_i,
  output logic [DIGIT_W*NUM_DIGITS-1:0] sum_o,
  output logic                          carry_o
);
  logic [NUM_DIGITS:0] chain;

  assign chain[0] = carry_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cell
    xs3_digit_cell u_cell (
      .aug_i   (aug_i[DIGIT_W*g +: DIGIT_W]),
      .add_i   (add_i[DIGIT_W*g +: DIGIT_W]),
      .carry_i (chain[g]),
      .sum_o   (sum_o[DIGIT_W*g +: DIGIT_W]),
      .carry_o (chain[g+1])
    );
  end

  assign carry_o = chain[NUM_DIGITS];
endmodule

// File: rtl/xs3_digit_adder_chk.sv
module xs3_digit_adder_chk #(
  parameter int NUM_DIGITS = 2
) (
  input logic [4*NUM_DIGITS-1:0] aug_i,
  input logic [4*NUM_DIGITS-1:0] add_i,
  input logic                    carry_i,
  input logic [4*NUM_DIGITS-1:0] sum_o,
  input logic                    carry_o
);
  function automatic bit all_legal(input logic [4*NUM_DIGITS-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (v[4*i +: 4] < 4'd3 || v[4*i +: 4] > 4'd12) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint to_dec(input logic [4*NUM_DIGITS-1:0] v);
    longint acc = 0;
    for (int i = NUM_DIGITS-1; i >= 0; i--)
      acc = acc*10 + longint'(v[4*i +: 4]) - 3;
    return acc;
  endfunction

  function automatic longint span();
    longint p = 1;
    for (int i = 0; i < NUM_DIGITS; i++) p = p*10;
    return p;
  endfunction

  function automatic logic [4*NUM_DIGITS-1:0] fill(input logic [3:0] d);
    logic [4*NUM_DIGITS-1:0] v;
    for (int i = 0; i < NUM_DIGITS; i++) v[4*i +: 4] = d;
    return v;
  endfunction

  always_comb begin
    if (all_legal(aug_i) && all_legal(add_i)) begin
      // R7: whole result equals the decimal sum
      assert_total_R7: assert (to_dec(sum_o) + (carry_o ? span() : 64'sd0)
                               == to_dec(aug_i) + to_dec(add_i) + longint'(carry_i))
        else $error("total mismatch");
      // R4: every output digit is a legal code
      assert_code_range_R4: assert (all_legal(sum_o))
        else $error("illegal output code");
      // R3: carry out exactly when the sum reaches the next decade
      assert_carry_R3: assert (carry_o ==
                               (to_dec(aug_i) + to_dec(add_i) + longint'(carry_i) >= span()))
        else $error("carry mismatch");
    end
    if (aug_i == fill(4'b0011) && add_i == fill(4'b0011) && !carry_i) begin
      assert_zero_R5: assert (sum_o == fill(4'b0011) && !carry_o)
        else $error("zero case wrong");
    end
    if (aug_i == fill(4'b1100) && add_i == fill(4'b1100) && carry_i) begin
      assert_full_R6: assert (sum_o == fill(4'b1100) && carry_o)
        else $error("full case wrong");
    end
  end
endmodule

bind xs3_digit_adder xs3_digit_adder_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (.*);

// File: tb/xs3_digit_adder_tb.sv
module xs3_digit_adder_tb_top;
  localparam int ND = 2;
  localparam int VW = 4*ND;

  logic clk;
  logic rst_n;
  logic [VW-1:0] aug, add, sum;
  logic cin, cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [VW-1:0] sum;
    logic          co;
    string         tag;
    int            a, b, c;
  } exp_t;
  exp_t sb_q[$];

  xs3_digit_adder #(.NUM_DIGITS(ND)) dut_i (
    .aug_i   (aug),
    .add_i   (add),
    .carry_i (cin),
    .sum_o   (sum),
    .carry_o (cout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R1: digit d coded as d+3, digit i in bits [4i+3:4i]
  function automatic logic [VW-1:0] enc(input int val);
    logic [VW-1:0] v;
    int r = val;
    for (int i = 0; i < ND; i++) begin
      v[4*i +: 4] = 4'((r % 10) + 3);
      r = r / 10;
    end
    return v;
  endfunction

  task automatic drive(input int a, input int b, input int c, input string tag);
    exp_t e;
    int tot;
    @(negedge clk);
    aug = enc(a);
    add = enc(b);
    cin = 1'(c);
    tot = a + b + c;
    e.sum = enc(tot % 100);
    e.co  = (tot >= 100);
    e.tag = tag;
    e.a = a; e.b = b; e.c = c;
    sb_q.push_back(e);
  endtask

  // monitor: one scoreboard item per rising edge
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (sum !== e.sum || cout !== e.co) begin
        n_fail++;
        $display("FAIL %s: %0d+%0d+%0d got sum=%h co=%b expected sum=%h co=%b",
                 e.tag, e.a, e.b, e.c, sum, cout, e.sum, e.co);
      end
    end
  end

  // R8: result visible without any clock edge
  task automatic settle_check(input int a, input int b, input int c);
    int tot;
    @(negedge clk);
    aug = enc(a); add = enc(b); cin = 1'(c);
    #1;
    tot = a + b + c;
    n_checks++;
    if (sum !== enc(tot % 100) || cout !== (tot >= 100)) begin
      n_fail++;
      $display("FAIL R8: %0d+%0d+%0d got sum=%h co=%b expected sum=%h co=%b",
               a, b, c, sum, cout, enc(tot % 100), (tot >= 100));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    aug = enc(0); add = enc(0); cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (sum !== 8'h33 || cout !== 1'b0) begin
      n_fail++;
      $display("FAIL R5 reset state: got sum=%h co=%b expected sum=33 co=0", sum, cout);
    end
    rst_n = 1'b1;

    // R2 R3 R4: lowest cell, all legal digit/carry combinations
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++)
          drive(a, b, c, "R2 R3 R4 low cell");

    // R7: upper cell always fed a carry from the lower cell
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++)
          drive(a*10 + 9, b*10 + 1, c, "R7 carry chain");

    // R1 R7: stride over whole operands
    for (int a = 0; a < 100; a += 7)
      for (int b = 0; b < 100; b += 13)
        drive(a, b, (a + b) % 2, "R1 R7 stride");

    drive(0, 0, 0, "R5 zero");
    drive(99, 99, 1, "R6 all nines");
    drive(9, 9, 1, "R6 cell max");
    drive(50, 49, 1, "R3 exact decade");

    repeat (3) @(posedge clk);
    settle_check(0, 0, 0);
    settle_check(45, 54, 1);
    settle_check(99, 99, 1);
    settle_check(17, 3, 0);

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule